// File: doc/BRIEF.md
# Burst Bus Response-Tracking Checker

This block sits passively beside a ready/valid burst memory bus whose commands and responses carry a source tag. It drives nothing on the bus. It keeps, for every source tag, a queue of the response obligations that accepted commands have created. A read obligation is one or more beats, worked out from the byte offset of the start address and the length field. A write obligation is a single acknowledgement, created when the final beat of the write burst is accepted.

Each accepted response beat is charged to the oldest obligation of its tag. The checker raises sticky error flags for four faults: an opcode that is neither read nor write, a response that arrives when its tag owes nothing, a command from a tag that lacks the needed permission, and a response whose last flag does not mark the final beat of the current transaction. A single clear input drops all four flags.

Top module: `rsp_track_checker`

## Requirements
- R1: A command or response counts only on a rising clock edge where its valid and ready are both high. A beat offered with ready low changes no flag and no obligation.
- R2: An accepted read (opcode 0) on tag T adds ceil((off + len + 1) / BYTES) response beats to T, where off is the low address bits inside a beat and len is the length field, which holds bytes minus one. Responding with exactly that many beats, with last high only on the final one, raises no flag.
- R3: An accepted write beat (opcode 1) adds one response beat to its tag only when its last input is high. Write beats with last low add nothing.
- R4: A response accepted while its tag owes zero beats sets errUnexpected and is not charged to any obligation.
- R5: Obligations are kept separately for each tag and are consumed in issue order within a tag. Responses on one tag do not affect the count of another.
- R6: An accepted command with opcode 2 or 3 sets errBadOpcode and creates no obligation.
- R7: A read from a tag whose READ_PERM bit is clear, or a write beat from a tag whose WRITE_PERM bit is clear, sets errPermission. The command still creates its normal obligation.
- R8: A charged response sets errLastMismatch when its last flag differs from "this is the final owed beat of the oldest transaction of its tag". The beat is still consumed.
- R9: Error flags hold until errClear is high on a clock edge with no new fault. A fault on the same edge as errClear leaves its flag set.
- R10: A synchronous active-high reset clears all flags and all obligations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| errClear | input | 1 | Clears all error flags |
| cmdValid | input | 1 | Command beat offered |
| cmdReady | input | 1 | Command beat taken by the target |
| cmdOpcode | input | 2 | 0 read, 1 write, others illegal |
| cmdLast | input | 1 | Final beat of the command burst |
| cmdSource | input | SRC_W | Source tag of the command |
| cmdAddrLow | input | OFS_W | Low address bits: byte offset inside a beat |
| cmdLength | input | LEN_W | Transfer size in bytes minus one |
| rspValid | input | 1 | Response beat offered |
| rspReady | input | 1 | Response beat taken by the initiator |
| rspSource | input | SRC_W | Source tag of the response |
| rspLast | input | 1 | Final beat of the response |
| errBadOpcode | output | 1 | Sticky illegal-opcode flag |
| errUnexpected | output | 1 | Sticky response-without-request flag |
| errPermission | output | 1 | Sticky permission flag |
| errLastMismatch | output | 1 | Sticky wrong-last flag |

## Verification
The properties assume that no tag ever has more than QDEPTH transactions outstanding, because the per-tag queue does not report overflow. They also assume that reset is held from time zero. The stimulus keeps to this by letting each tag have at most two transactions pending before it responds. It drives all inputs on the falling edge and reads the flags one falling edge after the accepting rising edge.

// File: rtl/rsp_track_pkg.sv
package rsp_track_pkg;
  localparam int OPC_W = 2;
  localparam logic [OPC_W-1:0] OPC_READ  = 2'd0;
  localparam logic [OPC_W-1:0] OPC_WRITE = 2'd1;

  // strobes from control to datapath
  typedef struct packed {
    logic push;
    logic pop;
    logic setOpc;
    logic setUnexp;
    logic setPerm;
    logic setLast;
  } strobes_t;
endpackage

// File: rtl/rsp_track_ctrl.sv
module rsp_track_ctrl
  import rsp_track_pkg::*;
#(
  parameter int SRC_W = 2,
  parameter int LEN_W = 8,
  parameter int BYTES = 4,
  parameter logic [(1<<SRC_W)-1:0] READ_PERM  = '1,
  parameter logic [(1<<SRC_W)-1:0] WRITE_PERM = '1,
  localparam int NTAG   = 1 << SRC_W,
  localparam int OFS_W  = $clog2(BYTES),
  localparam int MAXB   = (2*(BYTES-1) + (1<<LEN_W)) / BYTES,
  localparam int BCNT_W = $clog2(MAXB+1)
) (
  input  logic              cmdValid,
  input  logic              cmdReady,
  input  logic [OPC_W-1:0]  cmdOpcode,
  input  logic              cmdLast,
  input  logic [SRC_W-1:0]  cmdSource,
  input  logic [OFS_W-1:0]  cmdAddrLow,
  input  logic [LEN_W-1:0]  cmdLength,
  input  logic              rspValid,
  input  logic              rspReady,
  input  logic [SRC_W-1:0]  rspSource,
  input  logic              rspLast,
  input  logic [NTAG-1:0]   owedZero,
  input  logic [NTAG-1:0]   headFinal,
  output strobes_t          strb,
  output logic [SRC_W-1:0]  pushTag,
  output logic [BCNT_W-1:0] pushBeats,
  output logic [SRC_W-1:0]  popTag
);
  localparam int SUM_W = LEN_W + OFS_W + 1;

  logic             cmdFire, rspFire, isRead, isWrite;
  logic [SUM_W-1:0] roundUp;
  logic [BCNT_W-1:0] readBeats;

  always_comb begin
    cmdFire = cmdValid && cmdReady;
    rspFire = rspValid && rspReady;
    isRead  = cmdOpcode == OPC_READ;
    isWrite = cmdOpcode == OPC_WRITE;
    // offset + (len+1) bytes, rounded up to whole beats
    roundUp   = SUM_W'(cmdAddrLow) + SUM_W'(cmdLength) + SUM_W'(BYTES);
    readBeats = BCNT_W'(roundUp >> OFS_W);

    pushTag   = cmdSource;
    pushBeats = isRead ? readBeats : BCNT_W'(1);
    popTag    = rspSource;

    strb.push     = cmdFire && (isRead || (isWrite && cmdLast));
    strb.setOpc   = cmdFire && !isRead && !isWrite;
    strb.setPerm  = cmdFire && ((isRead && !READ_PERM[cmdSource]) ||
                                (isWrite && !WRITE_PERM[cmdSource]));
    strb.pop      = rspFire && !owedZero[rspSource];
    strb.setUnexp = rspFire && owedZero[rspSource];
    strb.setLast  = strb.pop && (rspLast != headFinal[rspSource]);
  end
endmodule

// File: rtl/rsp_track_dp.sv
module rsp_track_dp
  import rsp_track_pkg::*;
#(
  parameter int SRC_W  = 2,
  parameter int LEN_W  = 8,
  parameter int BYTES  = 4,
  parameter int QDEPTH = 4,
  localparam int NTAG   = 1 << SRC_W,
  localparam int MAXB   = (2*(BYTES-1) + (1<<LEN_W)) / BYTES,
  localparam int BCNT_W = $clog2(MAXB+1),
  localparam int OWED_W = $clog2(QDEPTH*MAXB+1),
  localparam int PTR_W  = $clog2(QDEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              errClear,
  input  strobes_t          strb,
  input  logic [SRC_W-1:0]  pushTag,
  input  logic [BCNT_W-1:0] pushBeats,
  input  logic [SRC_W-1:0]  popTag,
  output logic [NTAG-1:0]   owedZero,
  output logic [NTAG-1:0]   headFinal,
  output logic              errBadOpcode,
  output logic              errUnexpected,
  output logic              errPermission,
  output logic              errLastMismatch
);
  for (genvar t = 0; t < NTAG; t++) begin : g_tag
    logic [BCNT_W-1:0] fifo [QDEPTH];
    logic [PTR_W-1:0]  wrPtr, rdPtr;
    logic [BCNT_W-1:0] headCnt;
    logic [OWED_W-1:0] owed;
    logic              pushHere, popHere, headDone;

    assign pushHere = strb.push && (pushTag == SRC_W'(t));
    assign popHere  = strb.pop && (popTag == SRC_W'(t));
    assign headDone = (headCnt + BCNT_W'(1)) == fifo[rdPtr];

    always_ff @(posedge clk) begin
      if (pushHere) fifo[wrPtr] <= pushBeats;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        wrPtr   <= '0;
        rdPtr   <= '0;
        headCnt <= '0;
        owed    <= '0;
      end else begin
        if (pushHere) wrPtr <= wrPtr + PTR_W'(1);
        if (popHere) begin
          if (headDone) begin
            rdPtr   <= rdPtr + PTR_W'(1);
            headCnt <= '0;
          end else begin
            headCnt <= headCnt + BCNT_W'(1);
          end
        end
        owed <= owed + (pushHere ? OWED_W'(pushBeats) : '0)
                     - (popHere ? OWED_W'(1) : '0);
      end
    end

    assign owedZero[t]  = owed == '0;
    assign headFinal[t] = headDone;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      errBadOpcode    <= 1'b0;
      errUnexpected   <= 1'b0;
      errPermission   <= 1'b0;
      errLastMismatch <= 1'b0;
    end else begin
      errBadOpcode    <= strb.setOpc   || (errBadOpcode    && !errClear);
      errUnexpected   <= strb.setUnexp || (errUnexpected   && !errClear);
      errPermission   <= strb.setPerm  || (errPermission   && !errClear);
      errLastMismatch <= strb.setLast  || (errLastMismatch && !errClear);
    end
  end
endmodule

// File: rtl/rsp_track_checker.sv
module rsp_track_checker
  import rsp_track_pkg::*;
#(
  parameter int SRC_W  = 2,
  parameter int LEN_W  = 8,
  parameter int BYTES  = 4,
  parameter int QDEPTH = 4,
  parameter logic [(1<<SRC_W)-1:0] READ_PERM  = 4'b1011,
  parameter logic [(1<<SRC_W)-1:0] WRITE_PERM = 4'b0111,
  localparam int NTAG   = 1 << SRC_W,
  localparam int OFS_W  = $clog2(BYTES),
  localparam int MAXB   = (2*(BYTES-1) + (1<<LEN_W)) / BYTES,
  localparam int BCNT_W = $clog2(MAXB+1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             errClear,
  input  logic             cmdValid,
  input  logic             cmdReady,
  input  logic [OPC_W-1:0] cmdOpcode,
  input  logic             cmdLast,
  input  logic [SRC_W-1:0] cmdSource,
  input  logic [OFS_W-1:0] cmdAddrLow,
  input  logic [LEN_W-1:0] cmdLength,
  input  logic             rspValid,
  input  logic             rspReady,
  input  logic [SRC_W-1:0] rspSource,
  input  logic             rspLast,
  output logic             errBadOpcode,
  output logic             errUnexpected,
  output logic             errPermission,
  output logic             errLastMismatch
);
  strobes_t          strb;
  logic [SRC_W-1:0]  pushTag, popTag;
  logic [BCNT_W-1:0] pushBeats;
  logic [NTAG-1:0]   owedZero, headFinal;

  rsp_track_ctrl #(
    .SRC_W(SRC_W), .LEN_W(LEN_W), .BYTES(BYTES),
    .READ_PERM(READ_PERM), .WRITE_PERM(WRITE_PERM)
  ) u_ctrl (
    .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdOpcode(cmdOpcode),
    .cmdLast(cmdLast), .cmdSource(cmdSource), .cmdAddrLow(cmdAddrLow),
    .cmdLength(cmdLength), .rspValid(rspValid), .rspReady(rspReady),
    .rspSource(rspSource), .rspLast(rspLast), .owedZero(owedZero),
    .headFinal(headFinal), .strb(strb), .pushTag(pushTag),
    .pushBeats(pushBeats), .popTag(popTag)
  );

  rsp_track_dp #(
    .SRC_W(SRC_W), .LEN_W(LEN_W), .BYTES(BYTES), .QDEPTH(QDEPTH)
  ) u_dp (
    .clk(clk), .rst(rst), .errClear(errClear), .strb(strb),
    .pushTag(pushTag), .pushBeats(pushBeats), .popTag(popTag),
    .owedZero(owedZero), .headFinal(headFinal),
    .errBadOpcode(errBadOpcode), .errUnexpected(errUnexpected),
    .errPermission(errPermission), .errLastMismatch(errLastMismatch)
  );
endmodule

// File: rtl/rsp_track_sva.sv
module rsp_track_sva
  import rsp_track_pkg::*;
#(
  parameter int SRC_W = 2,
  parameter logic [(1<<SRC_W)-1:0] READ_PERM  = '1,
  parameter logic [(1<<SRC_W)-1:0] WRITE_PERM = '1,
  localparam int NTAG = 1 << SRC_W
) (
  input logic             clk,
  input logic             rst,
  input logic             errClear,
  input logic             cmdValid,
  input logic             cmdReady,
  input logic [OPC_W-1:0] cmdOpcode,
  input logic [SRC_W-1:0] cmdSource,
  input logic             rspValid,
  input logic             rspReady,
  input logic [SRC_W-1:0] rspSource,
  input logic [NTAG-1:0]  owedZero,
  input logic             errBadOpcode,
  input logic             errUnexpected,
  input logic             errPermission,
  input logic             errLastMismatch
);
  logic cmdFire, rspFire;
  assign cmdFire = cmdValid && cmdReady;
  assign rspFire = rspValid && rspReady;

  assert_bad_opcode_R6: assert property (@(posedge clk) disable iff (rst)
    cmdFire && (cmdOpcode > OPC_WRITE) |=> errBadOpcode);

  assert_opcode_cause_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(errBadOpcode) |-> $past(cmdFire));

  assert_unexpected_R4: assert property (@(posedge clk) disable iff (rst)
    rspFire && owedZero[rspSource] |=> errUnexpected);

  assert_read_perm_R7: assert property (@(posedge clk) disable iff (rst)
    cmdFire && (cmdOpcode == OPC_READ) && !READ_PERM[cmdSource] |=> errPermission);

  assert_write_perm_R7: assert property (@(posedge clk) disable iff (rst)
    cmdFire && (cmdOpcode == OPC_WRITE) && !WRITE_PERM[cmdSource] |=> errPermission);

  assert_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    !errClear && (errBadOpcode || errUnexpected || errPermission || errLastMismatch)
    |=> $countones({errBadOpcode, errUnexpected, errPermission, errLastMismatch}) != 0);

  assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
    errClear && !cmdFire && !rspFire
    |=> !errBadOpcode && !errUnexpected && !errPermission && !errLastMismatch);
endmodule

bind rsp_track_checker rsp_track_sva #(
  .SRC_W(SRC_W), .READ_PERM(READ_PERM), .WRITE_PERM(WRITE_PERM)
) u_sva (
  .clk(clk), .rst(rst), .errClear(errClear), .cmdValid(cmdValid),
  .cmdReady(cmdReady), .cmdOpcode(cmdOpcode), .cmdSource(cmdSource),
  .rspValid(rspValid), .rspReady(rspReady), .rspSource(rspSource),
  .owedZero(owedZero), .errBadOpcode(errBadOpcode),
  .errUnexpected(errUnexpected), .errPermission(errPermission),
  .errLastMismatch(errLastMismatch)
);

// File: tb/rsp_track_checker_bench.sv
module rsp_track_checker_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       errClear = 1'b0;
  logic       cmdValid = 1'b0, cmdReady = 1'b1, cmdLast = 1'b0;
  logic [1:0] cmdOpcode = '0, cmdSource = '0;
  logic [1:0] cmdAddrLow = '0;
  logic [7:0] cmdLength = '0;
  logic       rspValid = 1'b0, rspReady = 1'b1, rspLast = 1'b0;
  logic [1:0] rspSource = '0;
  logic       errBadOpcode, errUnexpected, errPermission, errLastMismatch;
  int         tests = 0, fails = 0;
  bit         done = 0;

  always #5 clk = ~clk;

  rsp_track_checker u_rsp_track_checker (
    .clk(clk), .rst(rst), .errClear(errClear), .cmdValid(cmdValid),
    .cmdReady(cmdReady), .cmdOpcode(cmdOpcode), .cmdLast(cmdLast),
    .cmdSource(cmdSource), .cmdAddrLow(cmdAddrLow), .cmdLength(cmdLength),
    .rspValid(rspValid), .rspReady(rspReady), .rspSource(rspSource),
    .rspLast(rspLast), .errBadOpcode(errBadOpcode),
    .errUnexpected(errUnexpected), .errPermission(errPermission),
    .errLastMismatch(errLastMismatch)
  );

  // {address low 16 bits, length, expected read beats}
  localparam logic [31:0] VEC [9] = '{
    {16'h0000, 8'd0,   8'd1},  {16'h0003, 8'd0,   8'd1},
    {16'h0003, 8'd1,   8'd2},  {16'h0010, 8'd3,   8'd1},
    {16'h0011, 8'd3,   8'd2},  {16'h0020, 8'd7,   8'd2},
    {16'h0022, 8'd9,   8'd3},  {16'h0103, 8'd255, 8'd65},
    {16'h0100, 8'd255, 8'd64}
  };

  // flags packed as {opcode, unexpected, permission, last}
  task automatic check(input string req, input logic [3:0] expFlags);
    logic [3:0] act;
    act = {errBadOpcode, errUnexpected, errPermission, errLastMismatch};
    tests++;
    if (act !== expFlags) begin
      fails++;
      $display("FAIL %s: flags=%b expected %b", req, act, expFlags);
    end
  endtask

  task automatic sendCmd(input logic [1:0] op, input logic last,
                         input logic [1:0] src, input logic [15:0] addr,
                         input logic [7:0] len);
    @(negedge clk);
    cmdOpcode = op; cmdLast = last; cmdSource = src;
    cmdAddrLow = addr[1:0]; cmdLength = len; cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic sendRsp(input logic [1:0] src, input logic last);
    @(negedge clk);
    rspSource = src; rspLast = last; rspValid = 1'b1;
    @(negedge clk);
    rspValid = 1'b0;
  endtask

  task automatic pulseClear();
    @(negedge clk); errClear = 1'b1;
    @(negedge clk); errClear = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: flags=timeout expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R10 reset state", 4'b0000);

    // R2 table walk: exact beats are clean, one more is unexpected (R4)
    for (int i = 0; i < 9; i++) begin
      sendCmd(2'd0, 1'b1, 2'd0, VEC[i][31:16], VEC[i][15:8]);
      for (int b = 0; b < int'(VEC[i][7:0]); b++)
        sendRsp(2'd0, b == int'(VEC[i][7:0]) - 1);
      check("R2 read beat count", 4'b0000);
      sendRsp(2'd0, 1'b1);
      check("R4 extra response", 4'b0100);
      pulseClear();
    end

    // R1: ready low on both channels
    @(negedge clk);
    cmdOpcode = 2'd3; cmdReady = 1'b0; cmdValid = 1'b1;
    rspSource = 2'd1; rspReady = 1'b0; rspValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0; rspValid = 1'b0; cmdReady = 1'b1; rspReady = 1'b1;
    check("R1 no handshake", 4'b0000);

    // R6: illegal opcode, no obligation created
    sendCmd(2'd2, 1'b1, 2'd1, 16'h0, 8'd0);
    check("R6 bad opcode", 4'b1000);
    sendRsp(2'd1, 1'b1);
    check("R6 no obligation", 4'b1100);
    pulseClear();

    // R3: write burst, only last beat owes a response
    sendCmd(2'd1, 1'b0, 2'd1, 16'h0, 8'd11);
    sendRsp(2'd1, 1'b1);
    check("R3 mid-burst owes nothing", 4'b0100);
    pulseClear();
    sendCmd(2'd1, 1'b0, 2'd1, 16'h0, 8'd11);
    sendCmd(2'd1, 1'b1, 2'd1, 16'h0, 8'd11);
    sendRsp(2'd1, 1'b1);
    check("R3 write acknowledged", 4'b0000);

    // R5: tags independent, in order within a tag
    sendCmd(2'd0, 1'b1, 2'd0, 16'h0, 8'd7);
    sendCmd(2'd1, 1'b1, 2'd1, 16'h0, 8'd3);
    sendRsp(2'd1, 1'b1);
    sendRsp(2'd0, 1'b0);
    sendRsp(2'd0, 1'b1);
    check("R5 interleaved tags", 4'b0000);
    sendCmd(2'd0, 1'b1, 2'd0, 16'h0022, 8'd9);
    sendCmd(2'd0, 1'b1, 2'd0, 16'h0000, 8'd0);
    sendRsp(2'd0, 1'b0);
    sendRsp(2'd0, 1'b0);
    sendRsp(2'd0, 1'b1);
    sendRsp(2'd0, 1'b1);
    check("R5 queued order", 4'b0000);

    // R7: permissions (READ_PERM=1011, WRITE_PERM=0111)
    sendCmd(2'd0, 1'b1, 2'd2, 16'h0, 8'd0);
    check("R7 read denied", 4'b0010);
    sendRsp(2'd2, 1'b1);
    check("R7 read still owed", 4'b0010);
    pulseClear();
    sendCmd(2'd1, 1'b1, 2'd3, 16'h0, 8'd0);
    check("R7 write denied", 4'b0010);
    sendRsp(2'd3, 1'b1);
    check("R7 write still owed", 4'b0010);
    pulseClear();

    // R8: last flag position
    sendCmd(2'd0, 1'b1, 2'd0, 16'h0, 8'd7);
    sendRsp(2'd0, 1'b1);
    check("R8 early last", 4'b0001);
    sendRsp(2'd0, 1'b1);
    check("R8 beat consumed", 4'b0001);
    pulseClear();
    sendCmd(2'd0, 1'b1, 2'd0, 16'h0, 8'd0);
    sendRsp(2'd0, 1'b0);
    check("R8 missing last", 4'b0001);
    pulseClear();

    // R9: sticky, cleared, new fault wins over clear
    sendCmd(2'd3, 1'b1, 2'd0, 16'h0, 8'd0);
    repeat (3) @(negedge clk);
    check("R9 sticky", 4'b1000);
    pulseClear();
    check("R9 cleared", 4'b0000);
    @(negedge clk);
    cmdOpcode = 2'd3; cmdValid = 1'b1; errClear = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0; errClear = 1'b0;
    check("R9 fault beats clear", 4'b1000);

    // R10: reset drops flags and obligations
    sendCmd(2'd0, 1'b1, 2'd0, 16'h0, 8'd7);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R10 flags after reset", 4'b0000);
    sendRsp(2'd0, 1'b1);
    check("R10 obligations dropped", 4'b0100);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule